// File: doc/BRIEF.md
# Counter/Timer with Receive-Timeout Mode

This block is the 16-bit down-counter of a two-channel UART controller. Software loads a 16-bit preset through two byte-wide writes and can read the live count one byte at a time. The counter advances only on cycles where the counter-clock enable `ct_tick` is high.

In free counter mode a start command loads the preset and counting begins. When the count reaches zero, the ready flag is set and the counter output pin drops from 1 to 0. The count then wraps to all ones and keeps running with no further visible effect. A stop command halts the count and clears the ready flag.

In receive-timeout mode the counter watches the two receivers instead. Each channel has a command input: a byte whose upper nibble is 0xA enables timeout for that channel, and one whose upper nibble is 0xC disables it. Every character-load pulse from an enabled receiver freezes the count for one counter tick, reloads the preset on that tick, and resumes counting on the ticks after it. If the count reaches zero, the ready flag signals that the line has gone quiet. The next character withdraws the flag. An interrupt mask gates the ready flag onto `irq`.

The control is a four-state machine:
- `CT_IDLE`: stopped.
- `CT_RUN`: counting.
- `CT_HOLD`: a character arrived; reload on the next tick.
- `CT_WAIT`: timeout armed, counter stopped until the first character.

The transitions are:
- start: `CT_IDLE`/`CT_RUN` → `CT_RUN`, counter mode only.
- stop: any state → `CT_IDLE`, counter mode only.
- arm (enable command): any state → `CT_WAIT`.
- restart (enabled load pulse): any state → `CT_HOLD`.
- reload tick: `CT_HOLD` → `CT_RUN`.
- mode-off drop: `CT_HOLD`/`CT_WAIT` → `CT_IDLE` once no channel is enabled.

Top module: `rx_timeout_counter`

## Requirements
- R1: After reset the count reads 0, `ready` and `irq` are 0, and `ct_out` is 1.
- R2: In counter mode a start command loads the preset {upper byte, lower byte}. Each later tick decrements the count. `rd_sel`=1 returns the upper count byte and `rd_sel`=0 returns the lower byte.
- R3: With preset P and a tick every cycle, `ready` rises and `ct_out` falls at the P-th clock edge after the start edge. The count then wraps to 0xFFFF and counting continues with `ready` held and `ct_out` held at 0.
- R4: In counter mode a stop command clears `ready` and freezes the count.
- R5: A preset of 0 gives a period of 65,536 ticks.
- R6: A channel command with upper nibble 0xA enables timeout for that channel, clears `ready`, and stops the counter until a character arrives. Upper nibble 0xC disables it. Any other value has no effect.
- R7: In timeout mode an enabled load pulse stops the count. The first tick after the pulse edge reloads the preset. `ready` rises P+1 ticks after the pulse edge.
- R8: A load pulse before expiry restarts the full period, so `ready` stays 0.
- R9: A load pulse after a timeout clears `ready` and withdraws `irq`.
- R10: While timeout mode is on, start and stop commands have no effect.
- R11: Load pulses from either enabled channel restart the counter. Pulses from a channel that is not enabled are ignored.
- R12: `irq` follows `ready` when `irq_mask` is 1 and is 0 when `irq_mask` is 0.
- R13: The count changes only on cycles with `ct_tick` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ct_tick | input | 1 | Counter-clock enable |
| preset_we_lo | input | 1 | Write `wr_data` to the preset low byte |
| preset_we_hi | input | 1 | Write `wr_data` to the preset high byte |
| wr_data | input | 8 | Preset write data |
| cmd_we | input | 2 | Per-channel command write strobe |
| cmd_data | input | 8 | Channel command byte |
| start_cmd | input | 1 | Start-counter command pulse |
| stop_cmd | input | 1 | Stop-counter command pulse |
| rd_sel | input | 1 | Selects the count byte on `rd_data` |
| rd_data | output | 8 | Live count byte |
| rx_load | input | 2 | Per-channel character-into-FIFO pulse |
| irq_mask | input | 1 | Interrupt enable for the ready flag |
| ready | output | 1 | Counter-ready flag |
| irq | output | 1 | Masked interrupt |
| ct_out | output | 1 | Counter output pin |

## Verification
Counter mode is driven with a two-byte preset, a zero preset and a gapped tick. These runs separate correct byte ordering, the 65,536 wrap period and tick gating from off-by-one expiry.

Timeout mode is driven in four patterns:
- a single arrival followed by silence, which checks the one-tick hold before the reload;
- an arrival that comes before expiry, which shows that a restart suppresses the flag;
- an arrival after expiry, which shows the flag being withdrawn;
- alternating arrivals from the two channels, which shows that either enabled channel restarts the counter while an unenabled one does not.

Start and stop commands, an unrecognised command nibble, and pulses after disable are each applied where they could alter the ready flag or the count. This shows which commands are ignored in each mode.

// File: rtl/ct_pkg.sv
package ct_pkg;
    typedef enum logic [1:0] {
        CT_IDLE = 2'd0,
        CT_RUN  = 2'd1,
        CT_HOLD = 2'd2,
        CT_WAIT = 2'd3
    } ct_state_t;

    localparam logic [3:0] CMD_TO_ON  = 4'hA;
    localparam logic [3:0] CMD_TO_OFF = 4'hC;
endpackage

// File: rtl/ct_preset_regs.sv
module ct_preset_regs #(
    parameter int BYTE_W = 8,
    localparam int CNT_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_lo,
    input  logic              we_hi,
    input  logic [BYTE_W-1:0] wdata,
    output logic [CNT_W-1:0]  preset
);
    logic [BYTE_W-1:0] lo_q, hi_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            if (we_lo) lo_q <= wdata;
            if (we_hi) hi_q <= wdata;
        end
    end

    assign preset = {hi_q, lo_q};
endmodule

// File: rtl/ct_mode_ctrl.sv
module ct_mode_ctrl #(
    parameter int N_CH   = 2,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_CH-1:0]   cmd_we,
    input  logic [BYTE_W-1:0] cmd_data,
    input  logic [N_CH-1:0]   rx_load,
    output logic              to_on,
    output logic              arm,
    output logic              restart
);
    import ct_pkg::*;

    logic [N_CH-1:0] en_q;
    logic [N_CH-1:0] on_hit;
    logic [3:0]      nib;

    assign nib = cmd_data[BYTE_W-1 -: 4];

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        assign on_hit[c] = cmd_we[c] && (nib == CMD_TO_ON);
        always_ff @(posedge clk) begin
            if (!rst_n)
                en_q[c] <= 1'b0;
            else if (on_hit[c])
                en_q[c] <= 1'b1;
            else if (cmd_we[c] && (nib == CMD_TO_OFF))
                en_q[c] <= 1'b0;
        end
    end

    assign to_on   = |en_q;
    assign arm     = |on_hit;
    assign restart = |(rx_load & en_q);
endmodule

// File: rtl/rx_timeout_counter.sv
module rx_timeout_counter #(
    parameter int BYTE_W = 8,
    parameter int N_CH   = 2,
    localparam int CNT_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ct_tick,
    input  logic              preset_we_lo,
    input  logic              preset_we_hi,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [N_CH-1:0]   cmd_we,
    input  logic [BYTE_W-1:0] cmd_data,
    input  logic              start_cmd,
    input  logic              stop_cmd,
    input  logic              rd_sel,
    output logic [BYTE_W-1:0] rd_data,
    input  logic [N_CH-1:0]   rx_load,
    input  logic              irq_mask,
    output logic              ready,
    output logic              irq,
    output logic              ct_out
);
    import ct_pkg::*;

    ct_state_t        st_q, st_d;
    logic [CNT_W-1:0] preset, cnt_q;
    logic             to_on, arm, restart;
    logic             expired_q, ready_q, out_q;
    logic             do_load, do_dec, clr_ready, hit;

    ct_preset_regs #(.BYTE_W(BYTE_W)) u_preset (
        .clk(clk), .rst_n(rst_n), .we_lo(preset_we_lo), .we_hi(preset_we_hi),
        .wdata(wr_data), .preset(preset)
    );

    ct_mode_ctrl #(.N_CH(N_CH), .BYTE_W(BYTE_W)) u_mode (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_data(cmd_data),
        .rx_load(rx_load), .to_on(to_on), .arm(arm), .restart(restart)
    );

    // Next-state logic
    always_comb begin
        st_d = st_q;
        if (arm) begin
            st_d = CT_WAIT;
        end else if (to_on) begin
            if (restart)
                st_d = CT_HOLD;
            else if (st_q == CT_HOLD && ct_tick)
                st_d = CT_RUN;
        end else begin
            if (stop_cmd)
                st_d = CT_IDLE;
            else if (start_cmd)
                st_d = CT_RUN;
            else begin
                unique case (st_q)
                    CT_HOLD, CT_WAIT: st_d = CT_IDLE;
                    default:          st_d = st_q;
                endcase
            end
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= CT_IDLE;
        else        st_q <= st_d;
    end

    // Datapath controls
    always_comb begin
        do_load   = !arm && (to_on ? (!restart && st_q == CT_HOLD && ct_tick)
                                   : (!stop_cmd && start_cmd));
        do_dec    = !arm && !do_load && st_q == CT_RUN && ct_tick &&
                    (to_on ? !restart : !stop_cmd);
        clr_ready = arm || (to_on && restart) || (!to_on && stop_cmd);
        hit       = do_dec && (cnt_q == CNT_W'(1)) && !expired_q;
    end

    // Outputs and count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            expired_q <= 1'b0;
            ready_q   <= 1'b0;
            out_q     <= 1'b1;
        end else begin
            if (do_load) begin
                cnt_q     <= preset;
                expired_q <= 1'b0;
                out_q     <= 1'b1;
            end else if (do_dec) begin
                cnt_q <= cnt_q - CNT_W'(1);
            end
            if (hit) begin
                expired_q <= 1'b1;
                out_q     <= 1'b0;
                ready_q   <= 1'b1;
            end else if (clr_ready) begin
                ready_q <= 1'b0;
            end
        end
    end

    assign ready   = ready_q;
    assign irq     = ready_q & irq_mask;
    assign ct_out  = out_q;
    assign rd_data = rd_sel ? cnt_q[CNT_W-1:BYTE_W] : cnt_q[BYTE_W-1:0];
endmodule

// File: rtl/ct_checker.sv
module ct_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ready,
    input logic             irq,
    input logic             irq_mask,
    input logic             ct_out,
    input logic             ct_tick,
    input logic             stop_cmd,
    input logic             to_on,
    input logic             arm,
    input logic             restart,
    input ct_pkg::ct_state_t st_q,
    input logic [CNT_W-1:0] cnt_q
);
    import ct_pkg::*;

    assert_stop_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_cmd && !to_on && !arm) |=> !ready);

    assert_arm_waits_R6: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (st_q == CT_WAIT && !ready));

    assert_hold_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CT_HOLD && to_on && !restart && !arm && ct_tick) |=> (st_q == CT_RUN));

    assert_restart_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && !arm) |=> (!ready && st_q == CT_HOLD));

    assert_out_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ct_out) |-> ready);

    assert_wait_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CT_WAIT && to_on && !restart && !arm) |=> $stable(cnt_q));

    assert_irq_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> irq_mask);
endmodule

bind rx_timeout_counter ct_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ready(ready), .irq(irq), .irq_mask(irq_mask),
    .ct_out(ct_out), .ct_tick(ct_tick), .stop_cmd(stop_cmd), .to_on(to_on),
    .arm(arm), .restart(restart), .st_q(st_q), .cnt_q(cnt_q)
);

// File: tb/tb_rx_timeout_counter.sv
`timescale 1ns/1ps
module tb_rx_timeout_counter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ct_tick = 1'b1;
    logic       preset_we_lo = 1'b0, preset_we_hi = 1'b0;
    logic [7:0] wr_data = '0;
    logic [1:0] cmd_we = '0;
    logic [7:0] cmd_data = '0;
    logic       start_cmd = 1'b0, stop_cmd = 1'b0;
    logic       rd_sel = 1'b0;
    logic [7:0] rd_data;
    logic [1:0] rx_load = '0;
    logic       irq_mask = 1'b1;
    logic       ready, irq, ct_out;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    rx_timeout_counter dut (
        .clk(clk), .rst_n(rst_n), .ct_tick(ct_tick),
        .preset_we_lo(preset_we_lo), .preset_we_hi(preset_we_hi), .wr_data(wr_data),
        .cmd_we(cmd_we), .cmd_data(cmd_data), .start_cmd(start_cmd), .stop_cmd(stop_cmd),
        .rd_sel(rd_sel), .rd_data(rd_data), .rx_load(rx_load), .irq_mask(irq_mask),
        .ready(ready), .irq(irq), .ct_out(ct_out)
    );

    task automatic check(input string req, input int got, input int exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic read_cnt(output logic [15:0] v);
        rd_sel = 1'b0; #0.5; v[7:0] = rd_data;
        rd_sel = 1'b1; #0.5; v[15:8] = rd_data;
        rd_sel = 1'b0;
    endtask

    task automatic set_preset(input logic [15:0] p);
        wr_data = p[7:0]; preset_we_lo = 1'b1; wait_n(1);
        preset_we_lo = 1'b0;
        wr_data = p[15:8]; preset_we_hi = 1'b1; wait_n(1);
        preset_we_hi = 1'b0;
    endtask

    task automatic pulse_start(); start_cmd = 1'b1; wait_n(1); start_cmd = 1'b0; endtask
    task automatic pulse_stop();  stop_cmd  = 1'b1; wait_n(1); stop_cmd  = 1'b0; endtask
    task automatic pulse_rx(input logic [1:0] ch); rx_load = ch; wait_n(1); rx_load = '0; endtask
    task automatic write_cmd(input logic [1:0] ch, input logic [7:0] b);
        cmd_data = b; cmd_we = ch; wait_n(1); cmd_we = '0;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        read_cnt(v);
        check("R1 count", v, 0);
        check("R1 ready", ready, 0);
        check("R1 irq", irq, 0);
        check("R1 ct_out", ct_out, 1);
    endtask

    task automatic t_counter();
        logic [15:0] v;
        set_preset(16'h0203);
        pulse_start();
        read_cnt(v);
        check("R2 loaded preset", v, 16'h0203);
        wait_n(514);
        read_cnt(v);
        check("R2 decrement", v, 1);
        check("R3 ready before zero", ready, 0);
        wait_n(1);
        check("R3 ready at zero", ready, 1);
        check("R3 ct_out falls", ct_out, 0);
        check("R12 irq masked on", irq, 1);
        wait_n(1);
        read_cnt(v);
        check("R3 wrap", v, 16'hFFFF);
        wait_n(3);
        check("R3 ready held", ready, 1);
        check("R3 ct_out held", ct_out, 0);
        irq_mask = 1'b0; #0.5;
        check("R12 irq masked off", irq, 0);
        irq_mask = 1'b1;
    endtask

    task automatic t_stop();
        logic [15:0] a, b;
        pulse_stop();
        check("R4 stop clears ready", ready, 0);
        read_cnt(a);
        wait_n(3);
        read_cnt(b);
        check("R4 frozen", b, a);
    endtask

    task automatic t_tick_gate();
        logic [15:0] v;
        set_preset(16'd10);
        ct_tick = 1'b0;
        pulse_start();
        wait_n(4);
        read_cnt(v);
        check("R13 no tick no count", v, 10);
        ct_tick = 1'b1;
        wait_n(3);
        read_cnt(v);
        check("R13 three ticks", v, 7);
        pulse_stop();
    endtask

    task automatic t_zero_preset();
        logic [15:0] v;
        set_preset(16'd0);
        pulse_start();
        wait_n(65535);
        read_cnt(v);
        check("R5 count one", v, 1);
        check("R5 not yet ready", ready, 0);
        wait_n(1);
        check("R5 ready after 65536", ready, 1);
        pulse_stop();
    endtask

    task automatic t_timeout_basic();
        logic [15:0] a, b;
        set_preset(16'd2);
        pulse_start();
        wait_n(2);
        check("R6 setup ready", ready, 1);
        write_cmd(2'b01, 8'hA0);
        check("R6 enable clears ready", ready, 0);
        read_cnt(a);
        wait_n(3);
        read_cnt(b);
        check("R6 stopped until char", b, a);
        set_preset(16'd4);
        pulse_rx(2'b10);
        wait_n(3);
        read_cnt(b);
        check("R11 unenabled channel ignored", b, a);
        pulse_rx(2'b01);
        wait_n(1);
        read_cnt(b);
        check("R7 reload after hold", b, 4);
        wait_n(3);
        read_cnt(b);
        check("R7 count", b, 1);
        check("R7 not yet ready", ready, 0);
        wait_n(1);
        check("R7 timeout ready", ready, 1);
        check("R12 timeout irq", irq, 1);
    endtask

    task automatic t_withdraw();
        pulse_rx(2'b01);
        check("R9 ready withdrawn", ready, 0);
        check("R9 irq withdrawn", irq, 0);
        wait_n(3);
        pulse_rx(2'b01);
        wait_n(4);
        check("R8 restart keeps ready low", ready, 0);
        wait_n(1);
        check("R8 expiry after restart", ready, 1);
    endtask

    task automatic t_ignored();
        logic [15:0] a, b;
        pulse_stop();
        check("R10 stop ignored", ready, 1);
        read_cnt(a);
        pulse_start();
        read_cnt(b);
        check("R10 start ignored", b, a - 16'd1);
    endtask

    task automatic t_two_channels();
        write_cmd(2'b10, 8'hA0);
        check("R6 second enable clears", ready, 0);
        pulse_rx(2'b10);
        wait_n(2);
        pulse_rx(2'b01);
        wait_n(3);
        check("R11 ch0 restarted after ch1", ready, 0);
        wait_n(1);
        check("R11 ready after both idle", ready, 0);
        wait_n(1);
        check("R11 ready timing", ready, 1);
    endtask

    task automatic t_disable();
        write_cmd(2'b01, 8'h50);
        check("R6 other nibble no effect", ready, 1);
        write_cmd(2'b11, 8'hC0);
        wait_n(1);
        pulse_stop();
        check("R6 disabled so stop works", ready, 0);
        pulse_start();
        wait_n(3);
        check("R6 counter mode again", ready, 0);
        wait_n(1);
        check("R6 counter mode expiry", ready, 1);
        pulse_rx(2'b01);
        check("R11 load ignored after disable", ready, 1);
    endtask

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);
        t_reset();
        t_counter();
        t_stop();
        t_tick_gate();
        t_zero_preset();
        t_timeout_basic();
        t_withdraw();
        t_ignored();
        t_two_channels();
        t_disable();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule